// File: doc/BRIEF.md
# Multicycle Processor Control State Machine

This block is the hardwired sequencer for a multicycle RISC datapath that has a single memory for instructions and data. It reads the opcode and function fields of the instruction register, the ALU zero flag and the sign bit of the ALU result. From these it drives every datapath control line in every cycle. These lines select the memory address source, request memory reads and writes, load the instruction register, choose the ALU operands and operation, choose and enable the PC update, select the jump target, and control register-file writes.

Nine states are visited in fixed flows. Every instruction starts with fetch and decode. A load then takes address, read and write-back states. A store takes address and store states. ALU-type instructions take execute and write-back states. All jumps, branches and system calls are resolved in one shared state, where the PC update is either unconditional or follows the ALU flags. The datapath, the memory and the register file are outside the block. The instruction register is loaded only at the end of fetch, so the op/fn inputs are stable for the rest of the instruction.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low, the state is forced at once to fetch (state 0) and the outputs equal the fetch pattern of R2. The first instruction then starts from fetch.
- R2: Fetch drives mem_rd=1, ir_wr=1, inst_data=0, alu_src_x=0, alu_src_y=0, alu_fn=add, pc_src=3 and pc_wr=1. The next state is always decode.
- R3: Decode drives alu_src_x=0, alu_src_y=3 and alu_fn=add. Opcodes 35 (load) and 43 (store) go to address. Opcode 0 with fn 32/34/36/37/38/39/42 and opcodes 8/10/12/13/14 go to execute. Opcodes 2 (j), 3 (jal), 4 (beq), 5 (bne) and 1 (bltz), and opcode 0 with fn 8 (jr) or 12 (syscall), go to the jump/branch state. Any other op/fn pair goes back to fetch.
- R4: Address drives alu_src_x=1, alu_src_y=2 and alu_fn=add, then goes to load-read for a load and to store for a store.
- R5: Load-read drives inst_data=1 and mem_rd=1. It is followed by load write-back, which drives reg_dst=0, reg_in_src=0 and reg_wr=1 and then returns to fetch.
- R6: Store drives inst_data=1 and mem_wr=1, then returns to fetch.
- R7: Execute drives alu_src_x=1. alu_src_y is 1 for opcode 0 and 2 for immediate opcodes. alu_fn uses the codes add=0, sub=1, and=2, or=3, xor=4, nor=5, slt=6. The mapping is fn 32/34/36/37/38/39/42 to add/sub/and/or/xor/nor/slt, and opcodes 8/10/12/13/14 to add/slt/and/or/xor. Execute is followed by ALU write-back, which drives reg_dst=1 for opcode 0 and 0 otherwise, reg_in_src=1 and reg_wr=1, then returns to fetch.
- R8: The jump/branch state drives alu_src_x=1, alu_src_y=1 and alu_fn=sub. jump_addr is 1 for syscall and 0 otherwise. pc_src is 0 for j, jal and syscall, 1 for jr and 2 for beq, bne and bltz. The next state is fetch.
- R9: In the jump/branch state, pc_wr is 1 for j, jr, jal and syscall. It equals alu_zero_i for beq, its inverse for bne, and alu_sign_i for bltz.
- R10: For jal, the jump/branch state also drives reg_wr=1, reg_dst=2 and reg_in_src=1.
- R11: Every control output that R2 to R10 do not set for the current state and instruction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 6 | Opcode field of the instruction register |
| fn_i | input | 6 | Function field of the instruction register |
| alu_zero_i | input | 1 | ALU result is zero |
| alu_sign_i | input | 1 | Most significant bit of the ALU result |
| inst_data_o | output | 1 | Memory address select: 0 PC, 1 ALU result |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_wr_o | output | 1 | Instruction register load |
| alu_src_x_o | output | 1 | ALU X operand: 0 PC, 1 register |
| alu_src_y_o | output | 2 | ALU Y operand: 0 constant 4, 1 register, 2 immediate, 3 shifted immediate |
| alu_fn_o | output | 3 | ALU operation code |
| pc_src_o | output | 2 | PC source: 0 jump target, 1 register, 2 branch target, 3 incremented PC |
| pc_wr_o | output | 1 | PC write enable |
| jump_addr_o | output | 1 | Jump target: 0 instruction field, 1 system-call vector |
| reg_dst_o | output | 2 | Destination: 0 rt, 1 rd, 2 link register |
| reg_in_src_o | output | 1 | Register write data: 0 memory, 1 ALU |
| reg_wr_o | output | 1 | Register file write |

## Verification
In the jump/branch state, jal updates the PC and writes the link register in the same cycle. The flag-driven PC write for a branch happens in the same cycle as the subtract that produces those flags. The bench runs every listed instruction through its whole flow under all four combinations of zero and sign flag. The whole control word is compared in every cycle, so a missing link write, a stray link write or a PC write that ignores or misreads the flags shows up as a mismatch. Undecodable op/fn pairs and a reset taken in the middle of an instruction are checked the same way.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int ST_W   = 4;
  localparam int AFN_W  = 3;
  localparam int PCS_W  = 2;
  localparam int SRCY_W = 2;
  localparam int RDST_W = 2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_BLTZ  = 6'd1;
  localparam logic [OP_W-1:0] OP_J     = 6'd2;
  localparam logic [OP_W-1:0] OP_JAL   = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OP_XORI  = 6'd14;
  localparam logic [OP_W-1:0] OP_LW    = 6'd35;
  localparam logic [OP_W-1:0] OP_SW    = 6'd43;

  localparam logic [FN_W-1:0] FN_JR    = 6'd8;
  localparam logic [FN_W-1:0] FN_SYS   = 6'd12;
  localparam logic [FN_W-1:0] FN_ADD   = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB   = 6'd34;
  localparam logic [FN_W-1:0] FN_AND   = 6'd36;
  localparam logic [FN_W-1:0] FN_OR    = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR   = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR   = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT   = 6'd42;

  // operand / source selector codes
  localparam logic [SRCY_W-1:0] SY_FOUR = 2'd0;
  localparam logic [SRCY_W-1:0] SY_REG  = 2'd1;
  localparam logic [SRCY_W-1:0] SY_IMM  = 2'd2;
  localparam logic [SRCY_W-1:0] SY_IMMS = 2'd3;
  localparam logic [PCS_W-1:0]  PS_JTGT = 2'd0;
  localparam logic [PCS_W-1:0]  PS_REG  = 2'd1;
  localparam logic [PCS_W-1:0]  PS_BTGT = 2'd2;
  localparam logic [PCS_W-1:0]  PS_INC  = 2'd3;
  localparam logic [RDST_W-1:0] RD_RT   = 2'd0;
  localparam logic [RDST_W-1:0] RD_RD   = 2'd1;
  localparam logic [RDST_W-1:0] RD_LINK = 2'd2;

  // numbering is fixed: other logic observes state codes
  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_JMPBR  = 4'd5,
    ST_STORE  = 4'd6,
    ST_EXEC   = 4'd7,
    ST_EXWB   = 4'd8
  } state_e;

  typedef enum logic [3:0] {
    IC_NONE, IC_LOAD, IC_STORE, IC_ALU_R, IC_ALU_I,
    IC_J, IC_JAL, IC_JR, IC_SYS, IC_BEQ, IC_BNE, IC_BLTZ
  } iclass_e;

  typedef enum logic [AFN_W-1:0] {
    AF_ADD = 3'd0, AF_SUB = 3'd1, AF_AND = 3'd2, AF_OR = 3'd3,
    AF_XOR = 3'd4, AF_NOR = 3'd5, AF_SLT = 3'd6
  } alu_fn_e;

  typedef struct packed {
    logic              inst_data;
    logic              mem_rd;
    logic              mem_wr;
    logic              ir_wr;
    logic              src_x;
    logic [SRCY_W-1:0] src_y;
    alu_fn_e           alu_fn;
    logic [PCS_W-1:0]  pc_src;
    logic              pc_wr;
    logic              jump_addr;
    logic [RDST_W-1:0] reg_dst;
    logic              reg_in_src;
    logic              reg_wr;
  } ctrl_t;
endpackage

// File: rtl/mc_instr_decode.sv
module mc_instr_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output iclass_e         iclass_o,
  output alu_fn_e         alu_fn_o
);
  always_comb begin
    iclass_o = IC_NONE;
    alu_fn_o = AF_ADD;
    case (op_i)
      OP_RTYPE: begin
        case (fn_i)
          FN_ADD: begin iclass_o = IC_ALU_R; alu_fn_o = AF_ADD; end
          FN_SUB: begin iclass_o = IC_ALU_R; alu_fn_o = AF_SUB; end
          FN_AND: begin iclass_o = IC_ALU_R; alu_fn_o = AF_AND; end
          FN_OR:  begin iclass_o = IC_ALU_R; alu_fn_o = AF_OR;  end
          FN_XOR: begin iclass_o = IC_ALU_R; alu_fn_o = AF_XOR; end
          FN_NOR: begin iclass_o = IC_ALU_R; alu_fn_o = AF_NOR; end
          FN_SLT: begin iclass_o = IC_ALU_R; alu_fn_o = AF_SLT; end
          FN_JR:  iclass_o = IC_JR;
          FN_SYS: iclass_o = IC_SYS;
          default: iclass_o = IC_NONE;
        endcase
      end
      OP_ADDI: begin iclass_o = IC_ALU_I; alu_fn_o = AF_ADD; end
      OP_SLTI: begin iclass_o = IC_ALU_I; alu_fn_o = AF_SLT; end
      OP_ANDI: begin iclass_o = IC_ALU_I; alu_fn_o = AF_AND; end
      OP_ORI:  begin iclass_o = IC_ALU_I; alu_fn_o = AF_OR;  end
      OP_XORI: begin iclass_o = IC_ALU_I; alu_fn_o = AF_XOR; end
      OP_LW:   iclass_o = IC_LOAD;
      OP_SW:   iclass_o = IC_STORE;
      OP_J:    iclass_o = IC_J;
      OP_JAL:  iclass_o = IC_JAL;
      OP_BEQ:  iclass_o = IC_BEQ;
      OP_BNE:  iclass_o = IC_BNE;
      OP_BLTZ: iclass_o = IC_BLTZ;
      default: iclass_o = IC_NONE;
    endcase
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  state_e  state_i,
  input  iclass_e iclass_i,
  output state_e  state_o
);
  always_comb begin
    state_o = ST_FETCH;
    case (state_i)
      ST_FETCH: state_o = ST_DECODE;
      ST_DECODE: begin
        case (iclass_i)
          IC_LOAD, IC_STORE: state_o = ST_ADDR;
          IC_ALU_R, IC_ALU_I: state_o = ST_EXEC;
          IC_J, IC_JAL, IC_JR, IC_SYS,
          IC_BEQ, IC_BNE, IC_BLTZ: state_o = ST_JMPBR;
          default: state_o = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (iclass_i == IC_LOAD)       state_o = ST_LDRD;
        else if (iclass_i == IC_STORE) state_o = ST_STORE;
        else                           state_o = ST_FETCH;
      end
      ST_LDRD: state_o = ST_LDWB;
      ST_EXEC: state_o = ST_EXWB;
      default: state_o = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e  state_i,
  input  iclass_e iclass_i,
  input  alu_fn_e alu_fn_i,
  input  logic    alu_zero_i,
  input  logic    alu_sign_i,
  output ctrl_t   ctrl_o
);
  logic br_take;

  // PC write rule of the shared jump/branch state
  always_comb begin
    case (iclass_i)
      IC_J, IC_JAL, IC_JR, IC_SYS: br_take = 1'b1;
      IC_BEQ:  br_take = alu_zero_i;
      IC_BNE:  br_take = ~alu_zero_i;
      IC_BLTZ: br_take = alu_sign_i;
      default: br_take = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_o = '0;
    case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_wr  = 1'b1;
        ctrl_o.src_y  = SY_FOUR;
        ctrl_o.alu_fn = AF_ADD;
        ctrl_o.pc_src = PS_INC;
        ctrl_o.pc_wr  = 1'b1;
      end
      ST_DECODE: begin
        ctrl_o.src_y  = SY_IMMS;
        ctrl_o.alu_fn = AF_ADD;
      end
      ST_ADDR: begin
        ctrl_o.src_x  = 1'b1;
        ctrl_o.src_y  = SY_IMM;
        ctrl_o.alu_fn = AF_ADD;
      end
      ST_LDRD: begin
        ctrl_o.inst_data = 1'b1;
        ctrl_o.mem_rd    = 1'b1;
      end
      ST_LDWB: begin
        ctrl_o.reg_dst = RD_RT;
        ctrl_o.reg_wr  = 1'b1;
      end
      ST_STORE: begin
        ctrl_o.inst_data = 1'b1;
        ctrl_o.mem_wr    = 1'b1;
      end
      ST_EXEC: begin
        ctrl_o.src_x  = 1'b1;
        ctrl_o.src_y  = (iclass_i == IC_ALU_R) ? SY_REG : SY_IMM;
        ctrl_o.alu_fn = alu_fn_i;
      end
      ST_EXWB: begin
        ctrl_o.reg_dst    = (iclass_i == IC_ALU_R) ? RD_RD : RD_RT;
        ctrl_o.reg_in_src = 1'b1;
        ctrl_o.reg_wr     = 1'b1;
      end
      ST_JMPBR: begin
        ctrl_o.src_x     = 1'b1;
        ctrl_o.src_y     = SY_REG;
        ctrl_o.alu_fn    = AF_SUB;
        ctrl_o.jump_addr = (iclass_i == IC_SYS);
        case (iclass_i)
          IC_JR:                    ctrl_o.pc_src = PS_REG;
          IC_BEQ, IC_BNE, IC_BLTZ:  ctrl_o.pc_src = PS_BTGT;
          default:                  ctrl_o.pc_src = PS_JTGT;
        endcase
        ctrl_o.pc_wr = br_take;
        if (iclass_i == IC_JAL) begin
          ctrl_o.reg_dst    = RD_LINK;
          ctrl_o.reg_in_src = 1'b1;
          ctrl_o.reg_wr     = 1'b1;
        end
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FN_W-1:0]   fn_i,
  input  logic              alu_zero_i,
  input  logic              alu_sign_i,
  output logic              inst_data_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              ir_wr_o,
  output logic              alu_src_x_o,
  output logic [SRCY_W-1:0] alu_src_y_o,
  output logic [AFN_W-1:0]  alu_fn_o,
  output logic [PCS_W-1:0]  pc_src_o,
  output logic              pc_wr_o,
  output logic              jump_addr_o,
  output logic [RDST_W-1:0] reg_dst_o,
  output logic              reg_in_src_o,
  output logic              reg_wr_o
);
  state_e  state_q, state_d;
  iclass_e iclass;
  alu_fn_e dec_fn;
  ctrl_t   ctrl;

  mc_instr_decode u_dec (
    .op_i     (op_i),
    .fn_i     (fn_i),
    .iclass_o (iclass),
    .alu_fn_o (dec_fn)
  );

  mc_next_state u_nxt (
    .state_i  (state_q),
    .iclass_i (iclass),
    .state_o  (state_d)
  );

  mc_ctrl_out u_out (
    .state_i    (state_q),
    .iclass_i   (iclass),
    .alu_fn_i   (dec_fn),
    .alu_zero_i (alu_zero_i),
    .alu_sign_i (alu_sign_i),
    .ctrl_o     (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign inst_data_o  = ctrl.inst_data;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign ir_wr_o      = ctrl.ir_wr;
  assign alu_src_x_o  = ctrl.src_x;
  assign alu_src_y_o  = ctrl.src_y;
  assign alu_fn_o     = ctrl.alu_fn;
  assign pc_src_o     = ctrl.pc_src;
  assign pc_wr_o      = ctrl.pc_wr;
  assign jump_addr_o  = ctrl.jump_addr;
  assign reg_dst_o    = ctrl.reg_dst;
  assign reg_in_src_o = ctrl.reg_in_src;
  assign reg_wr_o     = ctrl.reg_wr;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk
  import mc_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ST_W-1:0]   state_i,
  input logic [OP_W-1:0]   op_i,
  input logic              alu_zero_i,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic              ir_wr_o,
  input logic [SRCY_W-1:0] alu_src_y_o,
  input logic [PCS_W-1:0]  pc_src_o,
  input logic              pc_wr_o,
  input logic [RDST_W-1:0] reg_dst_o,
  input logic              reg_in_src_o,
  input logic              reg_wr_o
);
  a_r2_fetch_then_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |=> state_i == ST_DECODE);

  a_r2_ir_load_pattern: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |-> (mem_rd_o && pc_wr_o && pc_src_o == PS_INC));

  a_r3_decode_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_DECODE |-> alu_src_y_o == SY_IMMS);

  a_r5_load_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_LDRD |=> (reg_wr_o && reg_dst_o == RD_RT && !reg_in_src_o));

  a_r6_store_then_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ir_wr_o);

  a_r11_mem_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r9_beq_follows_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_JMPBR && op_i == OP_BEQ) |-> pc_wr_o == alu_zero_i);

  a_r10_link_with_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o && reg_dst_o == RD_LINK) |-> (pc_wr_o && reg_in_src_o));
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .op_i         (op_i),
  .alu_zero_i   (alu_zero_i),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .ir_wr_o      (ir_wr_o),
  .alu_src_y_o  (alu_src_y_o),
  .pc_src_o     (pc_src_o),
  .pc_wr_o      (pc_wr_o),
  .reg_dst_o    (reg_dst_o),
  .reg_in_src_o (reg_in_src_o),
  .reg_wr_o     (reg_wr_o)
);

// File: tb/mc_ctrl_fsm_test.sv
module mc_ctrl_fsm_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] op = '0, fn = '0;
  logic       zf = 1'b0, sf = 1'b0;
  logic       inst_data, mem_rd, mem_wr, ir_wr, src_x, pc_wr, jump_addr, reg_in_src, reg_wr;
  logic [1:0] src_y, pc_src, reg_dst;
  logic [2:0] alu_fn;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  mc_ctrl_fsm uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .fn_i(fn),
    .alu_zero_i(zf), .alu_sign_i(sf),
    .inst_data_o(inst_data), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_wr_o(ir_wr),
    .alu_src_x_o(src_x), .alu_src_y_o(src_y), .alu_fn_o(alu_fn),
    .pc_src_o(pc_src), .pc_wr_o(pc_wr), .jump_addr_o(jump_addr),
    .reg_dst_o(reg_dst), .reg_in_src_o(reg_in_src), .reg_wr_o(reg_wr)
  );

  // classes: 0 bad,1 lw,2 sw,3 R alu,4 imm alu,5 j,6 jal,7 jr,8 sys,9 beq,10 bne,11 bltz
  localparam int N_INSTR = 24;
  function automatic logic [17:0] instr_row(input int i);
    // {op, fn, class(4), alu code(2 unused hi bits dropped)} packed as op,fn,cls,afn
    case (i)
      0:  return {6'd35, 6'd0,  4'd1,  2'd0};
      1:  return {6'd43, 6'd0,  4'd2,  2'd0};
      2:  return {6'd0,  6'd32, 4'd3,  2'd0};
      3:  return {6'd0,  6'd34, 4'd3,  2'd0};
      4:  return {6'd0,  6'd36, 4'd3,  2'd0};
      5:  return {6'd0,  6'd37, 4'd3,  2'd0};
      6:  return {6'd0,  6'd38, 4'd3,  2'd0};
      7:  return {6'd0,  6'd39, 4'd3,  2'd0};
      8:  return {6'd0,  6'd42, 4'd3,  2'd0};
      9:  return {6'd8,  6'd5,  4'd4,  2'd0};
      10: return {6'd10, 6'd0,  4'd4,  2'd0};
      11: return {6'd12, 6'd0,  4'd4,  2'd0};
      12: return {6'd13, 6'd7,  4'd4,  2'd0};
      13: return {6'd14, 6'd0,  4'd4,  2'd0};
      14: return {6'd2,  6'd0,  4'd5,  2'd0};
      15: return {6'd3,  6'd0,  4'd6,  2'd0};
      16: return {6'd0,  6'd8,  4'd7,  2'd0};
      17: return {6'd0,  6'd12, 4'd8,  2'd0};
      18: return {6'd4,  6'd0,  4'd9,  2'd0};
      19: return {6'd5,  6'd0,  4'd10, 2'd0};
      20: return {6'd1,  6'd0,  4'd11, 2'd0};
      21: return {6'd63, 6'd0,  4'd0,  2'd0};
      22: return {6'd0,  6'd33, 4'd0,  2'd0};
      default: return {6'd20, 6'd32, 4'd0, 2'd0};
    endcase
  endfunction

  // expected ALU code in execute, from the R7 mapping
  function automatic logic [2:0] exp_afn(input logic [5:0] o, input logic [5:0] f);
    if (o == 6'd0) begin
      case (f)
        6'd32: return 3'd0; 6'd34: return 3'd1; 6'd36: return 3'd2;
        6'd37: return 3'd3; 6'd38: return 3'd4; 6'd39: return 3'd5;
        default: return 3'd6;
      endcase
    end
    case (o)
      6'd8: return 3'd0; 6'd10: return 3'd6; 6'd12: return 3'd2;
      6'd13: return 3'd3; default: return 3'd4;
    endcase
  endfunction

  function automatic int nxt(input int st, input int cls);
    case (st)
      0: return 1;
      1: return (cls == 1 || cls == 2) ? 2 : (cls == 3 || cls == 4) ? 7 : (cls >= 5) ? 5 : 0;
      2: return (cls == 1) ? 3 : 6;
      3: return 4;
      7: return 8;
      default: return 0;
    endcase
  endfunction

  // {id,mr,mw,iw,sx,sy,af,ps,pw,ja,rd,ris,rw}
  function automatic logic [17:0] exp_vec(input int st, input int cls, input logic [2:0] af,
                                          input logic z, input logic s);
    logic pw;
    case (st)
      0: return {1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,3'd0,2'd3,1'b1,1'b0,2'd0,1'b0,1'b0};
      1: return {5'b0,2'd3,3'd0,2'd0,1'b0,1'b0,2'd0,2'b0};
      2: return {4'b0,1'b1,2'd2,3'd0,2'd0,2'b0,2'd0,2'b0};
      3: return {1'b1,1'b1,16'b0};
      4: return {16'b0,1'b0,1'b1};
      6: return {1'b1,1'b0,1'b1,15'b0};
      7: return {4'b0,1'b1,(cls == 3) ? 2'd1 : 2'd2,af,2'd0,2'b0,2'd0,2'b0};
      8: return {14'b0,(cls == 3) ? 2'd1 : 2'd0,1'b1,1'b1};
      default: begin
        pw = (cls == 9) ? z : (cls == 10) ? !z : (cls == 11) ? s : 1'b1;
        return {4'b0,1'b1,2'd1,3'd1,
                (cls == 7) ? 2'd1 : (cls >= 9) ? 2'd2 : 2'd0,
                pw, (cls == 8),
                (cls == 6) ? 2'd2 : 2'd0, (cls == 6), (cls == 6)};
      end
    endcase
  endfunction

  function automatic string tag(input int st);
    case (st)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3, 4: return "R5";
      6: return "R6"; 7, 8: return "R7"; default: return "R8 R9 R10 R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [17:0] exp);
    logic [17:0] act;
    act = {inst_data, mem_rd, mem_wr, ir_wr, src_x, src_y, alu_fn, pc_src, pc_wr,
           jump_addr, reg_dst, reg_in_src, reg_wr};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s op=%0d fn=%0d z=%0b s=%0b actual=%b expected=%b",
               req, op, fn, zf, sf, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] row;
    int st, cls;
    logic [2:0] af;
    repeat (3) @(negedge clk);
    #1 check("R1 reset", exp_vec(0, 0, 3'd0, 1'b0, 1'b0));
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < N_INSTR; i++) begin
      row = instr_row(i);
      for (int zs = 0; zs < 4; zs++) begin
        op = row[17:12]; fn = row[11:6]; cls = int'(row[5:2]);
        zf = zs[0]; sf = zs[1];
        af = (cls == 3 || cls == 4) ? exp_afn(op, fn) : 3'd0;
        st = 0;
        do begin
          #1 check(tag(st), exp_vec(st, cls, af, zf, sf));
          @(posedge clk);
          st = nxt(st, cls);
          @(negedge clk);
        end while (st != 0);
      end
    end
    // R1: reset taken mid-instruction, from decode and from execute
    op = 6'd0; fn = 6'd32;
    for (int d = 1; d <= 2; d++) begin
      repeat (d) @(negedge clk);
      rst_ni = 1'b0;
      #1 check("R1 mid reset", exp_vec(0, 0, 3'd0, 1'b0, 1'b0));
      @(negedge clk);
      #1 check("R1 held reset", exp_vec(0, 0, 3'd0, 1'b0, 1'b0));
      @(negedge clk);
      rst_ni = 1'b1;
      #1 check("R1 resume fetch", exp_vec(0, 0, 3'd0, 1'b0, 1'b0));
      @(posedge clk);
      @(negedge clk);
      #1 check("R1 resume decode", exp_vec(1, 3, 3'd0, 1'b0, 1'b0));
      @(posedge clk);
      @(negedge clk);
      #1 check("R7 after reset", exp_vec(7, 3, 3'd0, 1'b0, 1'b0));
      @(posedge clk);
      @(negedge clk);
      #1 check("R7 wb after reset", exp_vec(8, 3, 3'd0, 1'b0, 1'b0));
      @(posedge clk);
      @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule